// File: doc/BRIEF.md
# Unsigned ALU with Overflow Word

This block is the arithmetic and logic unit of a small unsigned 16-bit processor. Each clock it takes a 4-bit operation code and two operands, a and b. One cycle later it presents a result word and a full-width overflow word. It also gives write-enable flags that tell the surrounding datapath whether the destination and the overflow register should be written. The four conditional-test operations write nothing. They return a single pass bit, which the sequencer uses to decide whether the next instruction is skipped.

Every arithmetic and shift operation defines all 16 bits of the overflow word. Depending on the operation this is a carry, a borrow mask, the high half of a product, a fixed-point fraction of a quotient, or the bits pushed out by a shift. This lets software chain the overflow into multi-word arithmetic. Operand fetch, writeback and cycle counting belong to the surrounding processor.

Top module: `ovw_alu`

## Requirements
- R1: Operation codes are 0x1 pass, 0x2 add, 0x3 subtract, 0x4 multiply, 0x5 divide, 0x6 remainder, 0x7 shift left, 0x8 shift right, 0x9 AND, 0xA OR, 0xB XOR, 0xC equal, 0xD not equal, 0xE greater-than, 0xF any-common-bit. Pass (0x1) returns b with result write set and overflow write clear.
- R2: Add returns (a+b) mod 2^16, sets overflow write, and gives overflow 0x0001 when the true sum exceeds 0xFFFF and 0x0000 otherwise.
- R3: Subtract returns (a-b) mod 2^16, sets overflow write, and gives overflow 0xFFFF when b > a and 0x0000 otherwise.
- R4: Multiply returns the low 16 bits of the 32-bit product and gives its high 16 bits as overflow, with overflow write set.
- R5: Divide returns the unsigned quotient a/b and gives overflow ((a*65536)/b) mod 65536, with overflow write set. When b is zero, both result and overflow are 0.
- R6: Remainder returns a mod b, or 0 when b is zero, with overflow write clear.
- R7: Shift left forms the 32-bit value a*2^b. It returns the low half and gives the high half as overflow, with overflow write set. Any b of 16 or more gives result 0, and any b of 32 or more also gives overflow 0.
- R8: Shift right forms the 32-bit value (a*65536)>>b. It returns the high half and gives the low half as overflow, with overflow write set. Any b of 16 or more gives result 0.
- R9: AND, OR and XOR return the bitwise combination with result write set and overflow write clear.
- R10: The test operations raise the test flag and clear both write enables. The pass bit is a==b (0xC), a!=b (0xD), unsigned a>b (0xE), or (a AND b)!=0 (0xF).
- R11: All outputs are registered and appear on the cycle after the inputs are sampled. While reset is low, all outputs are 0.
- R12: Opcode 0x0 is an idle code: all outputs are 0. On any operation whose overflow write is clear, the overflow output reads 0. On any test, the result reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand (destination value) |
| b_i | input | 16 | Second operand |
| res_o | output | 16 | Result word |
| ovf_o | output | 16 | Overflow word |
| res_we_o | output | 1 | Result should be written back |
| ovf_we_o | output | 1 | Overflow register should be written |
| test_o | output | 1 | Operation was a conditional test |
| pass_o | output | 1 | Test outcome |

## Verification
Uniform random operands exercise the general datapath of every opcode. Separate random draws restrict b to small values, so that shifts sweep the 0 to 40 range across the 16 and 32 boundaries and divisions regularly meet a zero divisor. Directed vectors cover the extremes: all-ones operands for carry and the largest product, zero minus one for borrow, equal operands for the greater-than and equal tests, and disjoint bit patterns for the common-bit test. Together these separate errors in result selection from errors in overflow formation or in the write-enable decode.

// File: rtl/ovw_alu_pkg.sv
`timescale 1ns/1ps
package ovw_alu_pkg;

   typedef enum logic [3:0] {
      OP_IDLE = 4'h0,
      OP_PASS = 4'h1,
      OP_ADD  = 4'h2,
      OP_SUB  = 4'h3,
      OP_MUL  = 4'h4,
      OP_DIV  = 4'h5,
      OP_REM  = 4'h6,
      OP_SHL  = 4'h7,
      OP_SHR  = 4'h8,
      OP_AND  = 4'h9,
      OP_OR   = 4'hA,
      OP_XOR  = 4'hB,
      OP_TEQ  = 4'hC,
      OP_TNE  = 4'hD,
      OP_TGT  = 4'hE,
      OP_TAND = 4'hF
   } alu_op_e;

   typedef enum logic [2:0] {
      U_NONE,
      U_ARITH,
      U_DIV,
      U_SHIFT,
      U_BITS
   } unit_e;

   function automatic logic op_is_test(alu_op_e op);
      return (op == OP_TEQ) || (op == OP_TNE) || (op == OP_TGT) || (op == OP_TAND);
   endfunction

   function automatic unit_e op_unit(alu_op_e op);
      unit_e u;
      case (op)
         OP_ADD, OP_SUB, OP_MUL:          u = U_ARITH;
         OP_DIV, OP_REM:                  u = U_DIV;
         OP_SHL, OP_SHR:                  u = U_SHIFT;
         OP_PASS, OP_AND, OP_OR, OP_XOR:  u = U_BITS;
         default:                         u = U_NONE;
      endcase
      return u;
   endfunction

endpackage

// File: rtl/ovw_arith.sv
`timescale 1ns/1ps
module ovw_arith
   import ovw_alu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  alu_op_e            op,
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   output logic [WIDTH-1:0]   res,
   output logic [WIDTH-1:0]   ovf
);
   localparam int WIDE = 2 * WIDTH;

   logic [WIDTH:0]   sum_x;
   logic [WIDTH:0]   dif_x;
   logic [WIDE-1:0]  prod;

   assign sum_x = {1'b0, a} + {1'b0, b};
   assign dif_x = {1'b0, a} - {1'b0, b};
   assign prod  = {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b};

   always_comb begin
      res = '0;
      ovf = '0;
      case (op)
         OP_ADD: begin
            res = sum_x[WIDTH-1:0];
            ovf = {{(WIDTH-1){1'b0}}, sum_x[WIDTH]};
         end
         OP_SUB: begin
            res = dif_x[WIDTH-1:0];
            ovf = {WIDTH{dif_x[WIDTH]}};
         end
         OP_MUL: begin
            res = prod[WIDTH-1:0];
            ovf = prod[WIDE-1:WIDTH];
         end
         default: begin
            res = '0;
            ovf = '0;
         end
      endcase
   end
endmodule

// File: rtl/ovw_divrem.sv
`timescale 1ns/1ps
module ovw_divrem
   import ovw_alu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  alu_op_e            op,
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   output logic [WIDTH-1:0]   res,
   output logic [WIDTH-1:0]   ovf
);
   localparam int WIDE = 2 * WIDTH;

   logic              b_zero;
   logic [WIDTH-1:0]  b_safe;
   logic [WIDTH-1:0]  quo;
   logic [WIDTH-1:0]  rem;
   logic [WIDTH-1:0]  frac;

   assign b_zero = (b == '0);
   assign b_safe = b_zero ? WIDTH'(1) : b;
   assign quo    = a / b_safe;
   assign rem    = a % b_safe;
   assign frac   = WIDTH'(({a, {WIDTH{1'b0}}}) / WIDE'(b_safe));

   always_comb begin
      res = '0;
      ovf = '0;
      if (!b_zero) begin
         case (op)
            OP_DIV: begin
               res = quo;
               ovf = frac;
            end
            OP_REM: res = rem;
            default: res = '0;
         endcase
      end
   end

   // quotient times divisor never exceeds the dividend
   always_comb begin
      if (op == OP_DIV && !b_zero)
         a_r5_quotient_bound: assert ((WIDE'(res) * WIDE'(b)) <= WIDE'(a));
   end
endmodule

// File: rtl/ovw_shifter.sv
`timescale 1ns/1ps
module ovw_shifter
   import ovw_alu_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter bit BARREL = 1'b1
) (
   input  alu_op_e            op,
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   output logic [WIDTH-1:0]   res,
   output logic [WIDTH-1:0]   ovf
);
   localparam int WIDE = 2 * WIDTH;
   localparam int SBIT = $clog2(WIDE);

   logic             left;
   logic             huge;
   logic [WIDE-1:0]  seed;
   logic [WIDE-1:0]  shifted;

   assign left = (op == OP_SHL);
   assign huge = ((b >> SBIT) != '0);
   assign seed = left ? {{WIDTH{1'b0}}, a} : {a, {WIDTH{1'b0}}};

   if (BARREL) begin : g_barrel
      logic [WIDE-1:0] stage [0:SBIT];
      assign stage[0] = seed;
      for (genvar s = 0; s < SBIT; s++) begin : g_stage
         assign stage[s+1] = !b[s] ? stage[s] :
                             (left ? (stage[s] << (1 << s)) : (stage[s] >> (1 << s)));
      end
      assign shifted = huge ? '0 : stage[SBIT];
   end else begin : g_direct
      logic [SBIT-1:0] amt;
      assign amt     = b[SBIT-1:0];
      assign shifted = huge ? '0 : (left ? (seed << amt) : (seed >> amt));
   end

   always_comb begin
      res = '0;
      ovf = '0;
      case (op)
         OP_SHL: begin
            res = shifted[WIDTH-1:0];
            ovf = shifted[WIDE-1:WIDTH];
         end
         OP_SHR: begin
            res = shifted[WIDE-1:WIDTH];
            ovf = shifted[WIDTH-1:0];
         end
         default: begin
            res = '0;
            ovf = '0;
         end
      endcase
   end

   // no bit may survive a shift that moves the operand fully out
   always_comb begin
      if ((op == OP_SHL || op == OP_SHR) && (b >= WIDTH'(WIDTH)))
         a_r7_wide_shift_clears: assert (res == '0);
   end
endmodule

// File: rtl/ovw_bitcmp.sv
`timescale 1ns/1ps
module ovw_bitcmp
   import ovw_alu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  alu_op_e            op,
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   output logic [WIDTH-1:0]   res,
   output logic               pass
);
   always_comb begin
      case (op)
         OP_PASS: res = b;
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         default: res = '0;
      endcase
   end

   always_comb begin
      case (op)
         OP_TEQ:  pass = (a == b);
         OP_TNE:  pass = (a != b);
         OP_TGT:  pass = (a > b);
         OP_TAND: pass = ((a & b) != '0);
         default: pass = 1'b0;
      endcase
   end
endmodule

// File: rtl/ovw_alu.sv
`timescale 1ns/1ps
module ovw_alu
   import ovw_alu_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter bit BARREL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         op_i,
   input  logic [WIDTH-1:0]   a_i,
   input  logic [WIDTH-1:0]   b_i,
   output logic [WIDTH-1:0]   res_o,
   output logic [WIDTH-1:0]   ovf_o,
   output logic               res_we_o,
   output logic               ovf_we_o,
   output logic               test_o,
   output logic               pass_o
);
   if (WIDTH < 4) begin : g_chk_min
      $error("ovw_alu: WIDTH must be at least 4");
   end
   if (WIDTH > 32) begin : g_chk_max
      $error("ovw_alu: WIDTH above 32 makes the fraction divider too deep");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_i);

   logic [WIDTH-1:0] ar_res, ar_ovf, dv_res, dv_ovf, sh_res, sh_ovf, bt_res;
   logic             bt_pass;

   ovw_arith #(.WIDTH(WIDTH)) u_arith (
      .op(op), .a(a_i), .b(b_i), .res(ar_res), .ovf(ar_ovf));

   ovw_divrem #(.WIDTH(WIDTH)) u_divrem (
      .op(op), .a(a_i), .b(b_i), .res(dv_res), .ovf(dv_ovf));

   ovw_shifter #(.WIDTH(WIDTH), .BARREL(BARREL)) u_shift (
      .op(op), .a(a_i), .b(b_i), .res(sh_res), .ovf(sh_ovf));

   ovw_bitcmp #(.WIDTH(WIDTH)) u_bits (
      .op(op), .a(a_i), .b(b_i), .res(bt_res), .pass(bt_pass));

   unit_e            unit;
   logic [WIDTH-1:0] res_d, ovf_d;
   logic             res_we_d, ovf_we_d, test_d, pass_d;

   always_comb begin
      unit     = op_unit(op);
      test_d   = op_is_test(op);
      pass_d   = test_d & bt_pass;
      res_we_d = (unit != U_NONE);
      ovf_we_d = (unit == U_ARITH) || (unit == U_SHIFT) || (op == OP_DIV);
      case (unit)
         U_ARITH: begin res_d = ar_res; ovf_d = ar_ovf; end
         U_DIV:   begin res_d = dv_res; ovf_d = dv_ovf; end
         U_SHIFT: begin res_d = sh_res; ovf_d = sh_ovf; end
         U_BITS:  begin res_d = bt_res; ovf_d = '0;     end
         default: begin res_d = '0;     ovf_d = '0;     end
      endcase
      if (!ovf_we_d) ovf_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_o    <= '0;
         ovf_o    <= '0;
         res_we_o <= 1'b0;
         ovf_we_o <= 1'b0;
         test_o   <= 1'b0;
         pass_o   <= 1'b0;
      end else begin
         res_o    <= res_d;
         ovf_o    <= ovf_d;
         res_we_o <= res_we_d;
         ovf_we_o <= ovf_we_d;
         test_o   <= test_d;
         pass_o   <= pass_d;
      end
   end

   a_r2_carry_is_bit: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_ADD) |-> (ovf_o <= WIDTH'(1)));

   a_r3_borrow_mask: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_SUB) |-> ((ovf_o == '0) || (ovf_o == '1)));

   a_r5_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_DIV && $past(b_i) == '0) |-> (res_o == '0 && ovf_o == '0));

   a_r6_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_REM && $past(b_i) != '0) |-> (res_o < $past(b_i)));

   a_r9_logic_keeps_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) inside {OP_AND, OP_OR, OP_XOR, OP_PASS}) |-> (!ovf_we_o && res_we_o));

   a_r10_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      test_o |-> (!res_we_o && !ovf_we_o && res_o == '0));

   a_r12_pass_needs_test: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> test_o);
endmodule

// File: tb/ovw_alu_tb.sv
`timescale 1ns/1ps
module ovw_alu_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_i = 4'h0;
   logic [15:0] a_i = 16'h0, b_i = 16'h0;
   logic [15:0] res_o, ovf_o;
   logic        res_we_o, ovf_we_o, test_o, pass_o;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   ovw_alu u_dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
      .res_o(res_o), .ovf_o(ovf_o), .res_we_o(res_we_o), .ovf_we_o(ovf_we_o),
      .test_o(test_o), .pass_o(pass_o));

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'h0: return "R12";
         4'h1: return "R1";
         4'h2: return "R2";
         4'h3: return "R3";
         4'h4: return "R4";
         4'h5: return "R5";
         4'h6: return "R6";
         4'h7: return "R7";
         4'h8: return "R8";
         4'h9, 4'hA, 4'hB: return "R9";
         default: return "R10";
      endcase
   endfunction

   // expected {res, ovf, res_we, ovf_we, test, pass}
   function automatic logic [35:0] model(input logic [3:0] op, input logic [15:0] a, b);
      logic [31:0] w;
      logic [15:0] r = 16'h0, o = 16'h0;
      logic rw = 1'b0, ow = 1'b0, t = 1'b0, p = 1'b0;
      case (op)
         4'h1: begin r = b; rw = 1; end
         4'h2: begin w = {16'h0, a} + {16'h0, b}; r = w[15:0];
                  o = (w > 32'hFFFF) ? 16'h1 : 16'h0; rw = 1; ow = 1; end
         4'h3: begin r = a - b; o = (b > a) ? 16'hFFFF : 16'h0; rw = 1; ow = 1; end
         4'h4: begin w = {16'h0, a} * {16'h0, b}; r = w[15:0]; o = w[31:16]; rw = 1; ow = 1; end
         4'h5: begin rw = 1; ow = 1;
                  if (b != 0) begin r = a / b; w = {a, 16'h0} / {16'h0, b}; o = w[15:0]; end
               end
         4'h6: begin rw = 1; r = (b == 0) ? 16'h0 : a % b; end
         4'h7: begin w = (b >= 32) ? 32'h0 : ({16'h0, a} << b); r = w[15:0]; o = w[31:16];
                  rw = 1; ow = 1; end
         4'h8: begin w = (b >= 32) ? 32'h0 : ({a, 16'h0} >> b); r = w[31:16]; o = w[15:0];
                  rw = 1; ow = 1; end
         4'h9: begin r = a & b; rw = 1; end
         4'hA: begin r = a | b; rw = 1; end
         4'hB: begin r = a ^ b; rw = 1; end
         4'hC: begin t = 1; p = (a == b); end
         4'hD: begin t = 1; p = (a != b); end
         4'hE: begin t = 1; p = (a > b); end
         4'hF: begin t = 1; p = ((a & b) != 0); end
         default: ;
      endcase
      return {r, o, rw, ow, t, p};
   endfunction

   task automatic run(input logic [3:0] op, input logic [15:0] a, b);
      logic [35:0] exp_v, got;
      @(negedge clk);
      op_i = op; a_i = a; b_i = b;
      @(negedge clk);
      exp_v = model(op, a, b);
      got   = {res_o, ovf_o, res_we_o, ovf_we_o, test_o, pass_o};
      checks++;
      if (got !== exp_v) begin
         errors++;
         $display("FAIL %s op=%h a=%h b=%h actual res=%h ovf=%h flags=%b expected res=%h ovf=%h flags=%b",
                  req_of(op), op, a, b, got[35:20], got[19:4], got[3:0],
                  exp_v[35:20], exp_v[19:4], exp_v[3:0]);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      op_i = 4'h2; a_i = 16'hFFFF; b_i = 16'hFFFF;
      repeat (3) @(negedge clk);
      checks++;   // R11: reset holds outputs at zero
      if ({res_o, ovf_o, res_we_o, ovf_we_o, test_o, pass_o} !== 36'h0) begin
         errors++;
         $display("FAIL R11 reset state actual=%h expected=0",
                  {res_o, ovf_o, res_we_o, ovf_we_o, test_o, pass_o});
      end
      rst_n = 1'b1;

      // directed corners
      run(4'h0, 16'h1234, 16'h5678);   // R12 idle
      run(4'h1, 16'h1111, 16'hBEEF);   // R1
      run(4'h2, 16'hFFFF, 16'h0001);   // R2 carry
      run(4'h2, 16'h1235, 16'hAABB);   // R2 no carry
      run(4'h3, 16'h0000, 16'h0001);   // R3 borrow
      run(4'h3, 16'h0005, 16'h0005);   // R3 equal
      run(4'h4, 16'hFFFF, 16'hFFFF);   // R4 max product
      run(4'h5, 16'h0005, 16'h0000);   // R5 divide by zero
      run(4'h5, 16'h0001, 16'h0003);   // R5 fraction
      run(4'h5, 16'hFFFF, 16'h0001);   // R5 unit divisor
      run(4'h6, 16'h0007, 16'h0000);   // R6 remainder by zero
      run(4'h6, 16'h0017, 16'h0005);   // R6
      run(4'h7, 16'h8001, 16'd16);     // R7 exactly out
      run(4'h7, 16'h8001, 16'd15);     // R7
      run(4'h7, 16'hFFFF, 16'd40);     // R7 beyond 32
      run(4'h7, 16'h00FF, 16'hFFF0);   // R7 huge amount
      run(4'h8, 16'h8001, 16'd17);     // R8
      run(4'h8, 16'hFFFF, 16'd32);     // R8 all gone
      run(4'h8, 16'h1234, 16'd0);      // R8 zero shift
      run(4'h9, 16'hF0F0, 16'h3C3C);   // R9
      run(4'hA, 16'hF0F0, 16'h0F0F);   // R9
      run(4'hB, 16'hFFFF, 16'h00FF);   // R9
      run(4'hE, 16'h8000, 16'h7FFF);   // R10 unsigned greater
      run(4'hE, 16'h4444, 16'h4444);   // R10 equal is not greater
      run(4'hF, 16'hAAAA, 16'h5555);   // R10 disjoint
      run(4'hC, 16'h0042, 16'h0042);   // R10
      run(4'hD, 16'h0042, 16'h0042);   // R10

      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic [3:0]  op;
         logic [15:0] a, b;
         op = 4'($urandom);
         a  = 16'($urandom);
         b  = 16'($urandom);
         case ($urandom % 4)
            0: b = 16'($urandom % 40);
            1: b = 16'($urandom % 3);
            2: if (op inside {4'hC, 4'hD, 4'hE}) b = a;
            default: ;
         endcase
         run(op, a, b);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule